// File: doc/BRIEF.md
# Digital Potentiometer Control Register Bank

This block keeps the control state of a 128-position digital potentiometer. A serial bus front end presents one byte-wide register access per cycle: a two-bit register select, a write strobe with its data byte, and a read path that returns the selected register in the same cycle. The bank holds the live wiper code, a shadow copy of the stored start-up wiper code, a two-bit mode register and an access control register. It drives the wiper code, an active-low shutdown control, the divider/rheostat mode select and a precision-disable control into the analog side.

Select 0 is shared by the live wiper code and the stored start-up code. The volatile-select flag in the access control register picks between them. While the external storage sequencer reports a write in progress, the bank refuses writes that would disturb either wiper copy or the access control register. Writes that must reach storage arm a request. The request is passed on as a one-cycle start pulse when the bus reports the STOP condition that ends the transaction.

Top module: `potreg_top`

## Requirements
- R1: After synchronous reset the wiper code and the stored-code shadow are both 40h, the volatile-select flag is 0, the shutdown control is 1 (running), both mode bits are 0, and no storage request is armed.
- R2: A read of select 0 returns the live wiper code when the volatile-select flag is 1 and the stored-code shadow when it is 0, zero-extended so that bit 7 reads 0.
- R3: An accepted write to select 0 with the volatile-select flag at 0 loads data bits 6:0 into both the shadow and the live wiper in the next cycle. With the flag at 1 it loads only the live wiper.
- R4: An accepted write to select 2 takes data bit 7 as the volatile-select flag and data bit 6 as the shutdown control. A read of select 2 returns flag in bit 7, shutdown control in bit 6, the current busy input in bit 5 and zeros in bits 4:0.
- R5: While the busy input is 1, writes to select 0 and select 2 change nothing.
- R6: A write to select 1 takes bit 7 as divider mode (1) versus rheostat (0) and bit 6 as precision-off. It is accepted whatever the busy input. Reads return those two bits with bits 5:0 as 0.
- R7: A write to select 1, or an accepted select-0 write with the flag at 0, arms a storage request. A STOP pulse with a request armed gives a one-cycle start pulse in the following cycle and clears the request. Writes that only touch the live wiper or select 2 arm nothing.
- R8: If a storage-arming write and a STOP pulse fall in the same cycle, the write's request stays armed for the next STOP. Any request armed before that cycle is still started by this STOP.
- R9: Select 3 reads as 00h, and writes to it change no state.
- R10: The wiper, shutdown, mode and precision outputs always equal the register contents. A higher code means a position nearer the high terminal, and 7Fh is the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select from the bus front end |
| wr_stb | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for the selected register (combinational) |
| stop_seen | input | 1 | One-cycle pulse when the bus STOP condition is detected |
| nv_busy | input | 1 | Storage write in progress, from the sequencer |
| wiper_code | output | TAP_BITS | Live wiper position |
| shutdown_n | output | 1 | 0 places the potentiometer in shutdown |
| divider_mode | output | 1 | 1 selects voltage divider, 0 rheostat |
| precision_off | output | 1 | 1 disables resistance matching |
| nv_start | output | 1 | One-cycle start request to the storage sequencer |

## Verification
The clashes that matter here are a storage-arming write landing in the same cycle as a STOP pulse, and a write landing while the busy input is high. The bench sets up both on purpose. It also produces them at random by driving strobe, STOP and busy independently each cycle. A behavioural model, updated at every edge, decides whether the start pulse belongs to the older request and whether the request stays armed. It also decides whether a write under busy was dropped. Every read and output is compared against that model every cycle.

// File: rtl/potreg_pkg.sv
package potreg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_WIPER = 2'd0,
        SEL_MODE  = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic vol;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic divider;
        logic prec_off;
    } mode_t;

    function automatic logic [BYTE_W-1:0] read_word(
        input reg_sel_e          sel,
        input ctrl_t             ctrl,
        input logic              busy,
        input mode_t             mode,
        input logic [BYTE_W-1:0] live,
        input logic [BYTE_W-1:0] shadow
    );
        logic [BYTE_W-1:0] w;
        w = '0;
        case (sel)
            SEL_WIPER: w = ctrl.vol ? live : shadow;
            SEL_MODE:  w[BYTE_W-1 -: 2] = {mode.divider, mode.prec_off};
            SEL_CTRL:  w[BYTE_W-1 -: 3] = {ctrl.vol, ctrl.run, busy};
            default:   w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/potreg_ctrl.sv
module potreg_ctrl
    import potreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  reg_sel_e          sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              busy,
    output ctrl_t             ctrl
);
    logic take;
    assign take = wr_stb && (sel == SEL_CTRL) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.vol <= 1'b0;
            ctrl.run <= 1'b1;
        end else if (take) begin
            ctrl.vol <= wdata[BYTE_W-1];
            ctrl.run <= wdata[BYTE_W-2];
        end
    end

    a_r5_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && sel == SEL_CTRL && busy) |=> ($stable(ctrl.vol) && $stable(ctrl.run)));

    a_r4_ctrl_loads: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && sel == SEL_CTRL && !busy) |=> (ctrl.vol == $past(wdata[BYTE_W-1])));
endmodule

// File: rtl/potreg_wiper.sv
module potreg_wiper
    import potreg_pkg::*;
#(
    parameter int TAP_BITS   = 7,
    parameter int RESET_CODE = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  reg_sel_e            sel,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                busy,
    input  logic                vol,
    output logic [TAP_BITS-1:0] live,
    output logic [TAP_BITS-1:0] shadow,
    output logic                nv_write
);
    localparam logic [TAP_BITS-1:0] RST_VAL = TAP_BITS'(RESET_CODE);

    logic take;
    assign take     = wr_stb && (sel == SEL_WIPER) && !busy;
    assign nv_write = take && !vol;

    always_ff @(posedge clk) begin
        if (rst) begin
            live   <= RST_VAL;
            shadow <= RST_VAL;
        end else if (take) begin
            live <= wdata[TAP_BITS-1:0];
            if (!vol) shadow <= wdata[TAP_BITS-1:0];
        end
    end

    a_r3_shadow_follows: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && sel == SEL_WIPER && !busy && !vol) |=> (live == shadow));

    a_r5_wiper_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && sel == SEL_WIPER && busy) |=> ($stable(live) && $stable(shadow)));
endmodule

// File: rtl/potreg_nvq.sv
module potreg_nvq
    import potreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  reg_sel_e          sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wiper_nv,
    input  logic              stop_seen,
    output mode_t             mode,
    output logic              start
);
    logic mode_take;
    logic armed;
    logic arm_now;

    assign mode_take = wr_stb && (sel == SEL_MODE);
    assign arm_now   = mode_take || wiper_nv;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= '0;
            armed <= 1'b0;
            start <= 1'b0;
        end else begin
            start <= stop_seen && armed;
            if (mode_take) begin
                mode.divider  <= wdata[BYTE_W-1];
                mode.prec_off <= wdata[BYTE_W-2];
            end
            if (arm_now)        armed <= 1'b1;
            else if (stop_seen) armed <= 1'b0;
        end
    end

    a_r7_start_after_stop: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(stop_seen));

    a_r7_start_single: assert property (@(posedge clk) disable iff (rst)
        start |=> !start || $past(stop_seen));

    a_r8_arm_survives_stop: assert property (@(posedge clk) disable iff (rst)
        (arm_now && stop_seen) |=> armed);
endmodule

// File: rtl/potreg_top.sv
module potreg_top
    import potreg_pkg::*;
#(
    parameter int TAP_BITS   = 7,
    parameter int RESET_CODE = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          reg_addr,
    input  logic                wr_stb,
    input  logic [7:0]          wr_data,
    output logic [7:0]          rd_data,
    input  logic                stop_seen,
    input  logic                nv_busy,
    output logic [TAP_BITS-1:0] wiper_code,
    output logic                shutdown_n,
    output logic                divider_mode,
    output logic                precision_off,
    output logic                nv_start
);
    reg_sel_e            sel;
    ctrl_t               ctrl;
    mode_t               mode;
    logic [TAP_BITS-1:0] live;
    logic [TAP_BITS-1:0] shadow;
    logic                wiper_nv;

    assign sel = reg_sel_e'(reg_addr);

    potreg_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .sel(sel),
        .wdata(wr_data), .busy(nv_busy), .ctrl(ctrl)
    );

    potreg_wiper #(.TAP_BITS(TAP_BITS), .RESET_CODE(RESET_CODE)) u_wiper (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .sel(sel), .wdata(wr_data),
        .busy(nv_busy), .vol(ctrl.vol), .live(live), .shadow(shadow),
        .nv_write(wiper_nv)
    );

    potreg_nvq u_nvq (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .sel(sel), .wdata(wr_data),
        .wiper_nv(wiper_nv), .stop_seen(stop_seen), .mode(mode), .start(nv_start)
    );

    assign rd_data = read_word(sel, ctrl, nv_busy, mode,
                               BYTE_W'(live), BYTE_W'(shadow));

    assign wiper_code    = live;
    assign shutdown_n    = ctrl.run;
    assign divider_mode  = mode.divider;
    assign precision_off = mode.prec_off;

    a_r2_wiper_msb_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> (rd_data[7] == 1'b0));

    a_r9_spare_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd3) |-> (rd_data == 8'h00));

    a_r10_wiper_out_tracks: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && reg_addr == 2'd3) |=> $stable(wiper_code));
endmodule

// File: tb/sim_potreg_top.sv
module sim_potreg_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = '0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       stop_seen = 1'b0;
    logic       nv_busy = 1'b0;
    logic [6:0] wiper_code;
    logic       shutdown_n, divider_mode, precision_off, nv_start;

    always #10 clk = ~clk;

    potreg_top u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_data(rd_data), .stop_seen(stop_seen),
        .nv_busy(nv_busy), .wiper_code(wiper_code), .shutdown_n(shutdown_n),
        .divider_mode(divider_mode), .precision_off(precision_off),
        .nv_start(nv_start)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // behavioural reference state
    int m_live, m_shadow, m_vol, m_run, m_div, m_prec, m_armed, m_start;
    bit started = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(int a);
        case (a)
            0: return m_vol ? m_live : m_shadow;
            1: return (m_div << 7) | (m_prec << 6);
            2: return (m_vol << 7) | (m_run << 6) | (int'(nv_busy) << 5);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int nvw;
        if (rst) begin
            m_live = 64; m_shadow = 64; m_vol = 0; m_run = 1;
            m_div = 0; m_prec = 0; m_armed = 0; m_start = 0;
            started = 1;
        end else begin
            m_start = (stop_seen && m_armed) ? 1 : 0;
            nvw = 0;
            if (wr_stb && reg_addr == 0 && !nv_busy) begin
                m_live = wr_data & 8'h7F;
                if (m_vol == 0) begin m_shadow = wr_data & 8'h7F; nvw = 1; end
            end
            if (wr_stb && reg_addr == 2 && !nv_busy) begin
                m_vol = wr_data[7]; m_run = wr_data[6];
            end
            if (wr_stb && reg_addr == 1) begin
                m_div = wr_data[7]; m_prec = wr_data[6]; nvw = 1;
            end
            if (nvw != 0) m_armed = 1;
            else if (stop_seen) m_armed = 0;
        end
        #5;
        if (started) begin
            chk("R10 wiper_code", wiper_code, m_live);
            chk("R10 shutdown_n", shutdown_n, m_run);
            chk("R6 divider_mode", divider_mode, m_div);
            chk("R6 precision_off", precision_off, m_prec);
            chk("R7 nv_start", nv_start, m_start);
            case (reg_addr)
                0: chk("R2 rd select0", rd_data, model_read(0));
                1: chk("R6 rd select1", rd_data, model_read(1));
                2: chk("R4 rd select2", rd_data, model_read(2));
                default: chk("R9 rd select3", rd_data, model_read(3));
            endcase
        end
    end

    task automatic drive(int a, bit s, int d, bit st, bit b);
        @(negedge clk);
        reg_addr = 2'(a); wr_stb = s; wr_data = 8'(d); stop_seen = st; nv_busy = b;
    endtask

    task automatic peek(int a, int exp, string tag);
        drive(a, 0, 0, 0, 0);
        #1 chk(tag, rd_data, exp);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        peek(0, 8'h40, "R1 shadow reset");
        peek(2, 8'h40, "R1 ctrl reset");
        peek(1, 8'h00, "R1 mode reset");
        chk("R1 wiper reset", wiper_code, 7'h40);
        // R3 write shadow + live with VOL=0
        drive(0, 1, 8'hA5, 0, 0);
        peek(0, 8'h25, "R3 shadow write");
        chk("R3 live follows", wiper_code, 7'h25);
        // R7 STOP starts the request
        drive(0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0);
        #1 chk("R7 start pulse", nv_start, 1);
        drive(0, 0, 0, 0, 0);
        #1 chk("R7 start single", nv_start, 0);
        // R4 set VOL=1, R3 live-only write, R2 read live
        drive(2, 1, 8'hC0, 0, 0);
        drive(0, 1, 8'h7F, 0, 0);
        peek(0, 8'h7F, "R2 read live");
        chk("R10 wiper top", wiper_code, 7'h7F);
        drive(0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0);
        #1 chk("R7 live write no request", nv_start, 0);
        // R5 busy lock
        drive(0, 1, 8'h11, 0, 1);
        drive(2, 1, 8'h00, 0, 1);
        peek(0, 8'h7F, "R5 wiper locked");
        peek(2, 8'hC0, "R5 ctrl locked");
        // R6 mode write under busy
        drive(1, 1, 8'hFF, 0, 1);
        peek(1, 8'hC0, "R6 mode accepted");
        // R8 arming write with STOP in the same cycle
        drive(0, 0, 0, 1, 0);  // starts the mode request
        drive(1, 1, 8'h80, 1, 0);
        drive(0, 0, 0, 0, 0);
        #1 chk("R8 no older request", nv_start, 0);
        drive(0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0);
        #1 chk("R8 kept for next stop", nv_start, 1);
        // R9 spare select
        drive(3, 1, 8'hFF, 0, 0);
        peek(3, 8'h00, "R9 spare read");
        peek(2, 8'hC0, "R9 ctrl untouched");
        chk("R9 wiper untouched", wiper_code, 7'h7F);
        // shutdown via ACR
        drive(2, 1, 8'h00, 0, 0);
        drive(0, 0, 0, 0, 0);
        #1 chk("R4 shutdown", shutdown_n, 0);
        // random traffic against the model
        for (int i = 0; i < 400; i++) begin
            drive($urandom_range(0, 3), ($urandom_range(0, 1) == 1),
                  $urandom_range(0, 255), ($urandom_range(0, 4) == 0),
                  ($urandom_range(0, 2) == 0));
        end
        drive(0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        summary();
    end
endmodule